// File: doc/BRIEF.md
# Quad Down-Counting Timer

This block holds four independent down-counters behind a single-cycle register bus. Each counter can run free, run periodically or fire once. Software writes a start value, picks a prescale of 1, 16 or 256 and a counter width of 16 or 32 bits, then enables the channel. A counter advances only in cycles where the shared `tick_en` input is high. The prescaler thins those ticks further before the counter sees them.

Each channel has a second reload register, the background value. Software can change it while the channel runs, and the new value takes effect only at the next expiry. Every expiry raises a sticky status bit for that channel. Software clears it by writing one to it. A mask selects which status bits reach the single `irq` output.

Reads are combinational from `bus_addr`. A write takes effect at the rising clock edge where `bus_we` is high.

Top module: `qtick_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low. All channels are disabled and all interrupts are masked.
- R2: The shared registers sit at fixed offsets: mask at 0x00, raw status at 0x04, masked status at 0x08 and clear at 0x0C. Bit n of each belongs to channel n. Channel n starts at 0x10+0x10*n. Within a channel, +0x0 is the start value, +0x4 the current count, +0x8 the control word and +0xC the background value. The start-value register reads back the last value written to it.
- R3: A write to a channel's start value sets the current count and the background value to the written data in the same edge. It also restarts that channel's prescaler, and it cancels any count step in that cycle.
- R4: Control bits 3:2 select the prescale: 00 divides by 1, 01 divides by 16, and 10 or 11 divide by 256. After a start-value write, the first count step falls on the 1st, 16th or 256th tick. A channel counts only when control bit 7 is set and `tick_en` is high.
- R5: Each count step decrements the current count by one. A step taken while the count is zero is an expiry.
- R6: Control bit 1 set selects 32-bit counting. Clear selects 16-bit counting, in which the current count reads only the low 16 bits with the upper bits zero. In free-running mode (bits 6 and 0 both clear), an expiry reloads all ones of the selected width.
- R7: In periodic mode (bit 6 set, bit 0 clear), an expiry reloads the background value. Writing the background value alone does not change the current count.
- R8: One-shot mode is bit 0 set, and it takes priority over bit 6. On expiry the count stays at zero and control bit 7 clears, so reading the control word back shows the channel stopped.
- R9: Every expiry of channel n sets raw status bit n, in every mode.
- R10: Writing one to bit n of the clear register clears raw bit n, and zero bits have no effect. An expiry in the same cycle as a clear leaves the raw bit set. The clear register reads zero.
- R11: Masked status reads raw status ANDed with the mask register. `irq` is high exactly when masked status is nonzero.
- R12: The control word keeps only bits 7, 6, 3, 2, 1 and 0, and the other bits read zero. Writes to the current-count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count tick qualifier, shared by all channels |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR of the masked status bits |

## Verification
A prescaler that falls out of phase shows up one tick early or late. It is visible in the current-count read at the first count step after a start-value write, which comes within 256 ticks. A wrong reload source or wrong wrap width appears in the count read in the cycle right after an expiry. A raw bit lost or set spuriously appears at once on the status reads and, when masked in, on `irq`. The random phase reads one register after every cycle, so a divergence surfaces within a cycle of the step that caused it.

// File: rtl/qtick_pkg.sv
package qtick_pkg;

  localparam int unsigned OFS_MASK   = 'h00;
  localparam int unsigned OFS_RAW    = 'h04;
  localparam int unsigned OFS_MSKD   = 'h08;
  localparam int unsigned OFS_CLR    = 'h0C;
  localparam int unsigned CH_BASE    = 'h10;
  localparam int unsigned CH_STRIDE  = 'h10;
  localparam int unsigned CH_LOAD    = 'h0;
  localparam int unsigned CH_COUNT   = 'h4;
  localparam int unsigned CH_CTRL    = 'h8;
  localparam int unsigned CH_BGND    = 'hC;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2
  } run_mode_e;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic [1:0] presc;
    logic       wide;
    logic       oneshot;
  } chan_ctrl_t;

  function automatic chan_ctrl_t ctrl_from_word(input logic [7:0] w);
    chan_ctrl_t c;
    c.en       = w[7];
    c.periodic = w[6];
    c.presc    = w[3:2];
    c.wide     = w[1];
    c.oneshot  = w[0];
    return c;
  endfunction

  function automatic logic [7:0] ctrl_to_word(input chan_ctrl_t c);
    return {c.en, c.periodic, 2'b00, c.presc, c.wide, c.oneshot};
  endfunction

  function automatic run_mode_e ctrl_mode(input chan_ctrl_t c);
    if (c.oneshot)       return MODE_ONESHOT;
    else if (c.periodic) return MODE_PERIODIC;
    else                 return MODE_FREE;
  endfunction

endpackage

// File: rtl/qtick_prescaler.sv
module qtick_prescaler #(
  parameter int unsigned MID_SHIFT = 4,
  parameter int unsigned TOP_SHIFT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] code,
  output logic       step
);
  localparam int unsigned PW = TOP_SHIFT;
  localparam logic [PW-1:0] MID_MASK = PW'((1 << MID_SHIFT) - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [PW-1:0] sel_mask;

  always_comb begin
    case (code)
      2'b00:   sel_mask = '0;
      2'b01:   sel_mask = MID_MASK;
      default: sel_mask = '1;
    endcase
  end

  assign step = run && ((pre_q & sel_mask) == sel_mask);

  always_comb begin
    pre_d = pre_q;
    if (restart)  pre_d = '0;
    else if (run) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/qtick_channel.sv
module qtick_channel
  import qtick_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_load,
  input  logic          wr_ctrl,
  input  logic          wr_bgnd,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] count_rd,
  output logic [CW-1:0] load_rd,
  output logic [CW-1:0] bgnd_rd,
  output logic [CW-1:0] ctrl_rd,
  output logic [CW-1:0] cnt_raw,
  output logic          expire
);
  localparam int unsigned HALF = CW / 2;
  localparam logic [CW-1:0] NARROW_ONES = {{(CW-HALF){1'b0}}, {HALF{1'b1}}};

  logic [CW-1:0] cnt_q, cnt_d, bg_q, bg_d, ld_q, ld_d;
  chan_ctrl_t    ctrl_q, ctrl_d;
  logic [CW-1:0] eff, reload;
  logic          run, step, fire, at_zero;
  run_mode_e     mode;

  assign eff     = ctrl_q.wide ? cnt_q : {{(CW-HALF){1'b0}}, cnt_q[HALF-1:0]};
  assign run     = tick_en && ctrl_q.en;
  assign mode    = ctrl_mode(ctrl_q);
  assign at_zero = (eff == '0);
  assign fire    = step && !wr_load;
  assign expire  = fire && at_zero;

  qtick_prescaler u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (wr_load),
    .code    (ctrl_q.presc),
    .step    (step)
  );

  always_comb begin
    case (mode)
      MODE_PERIODIC: reload = bg_q;
      MODE_ONESHOT:  reload = '0;
      default:       reload = ctrl_q.wide ? '1 : NARROW_ONES;
    endcase
  end

  always_comb begin
    cnt_d  = cnt_q;
    bg_d   = bg_q;
    ld_d   = ld_q;
    ctrl_d = ctrl_q;
    if (wr_load) begin
      cnt_d = wdata;
      bg_d  = wdata;
      ld_d  = wdata;
    end else if (fire) begin
      cnt_d = at_zero ? reload : eff - 1'b1;
    end
    if (wr_bgnd) bg_d = wdata;
    if (wr_ctrl)                               ctrl_d    = ctrl_from_word(wdata[7:0]);
    else if (expire && mode == MODE_ONESHOT)   ctrl_d.en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bg_q   <= '0;
      ld_q   <= '0;
      ctrl_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      bg_q   <= bg_d;
      ld_q   <= ld_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign count_rd = eff;
  assign load_rd  = ld_q;
  assign bgnd_rd  = bg_q;
  assign ctrl_rd  = CW'(ctrl_to_word(ctrl_q));
  assign cnt_raw  = cnt_q;
endmodule

// File: rtl/qtick_irq.sv
module qtick_irq #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mask,
  input  logic              wr_clr,
  input  logic [NUM_CH-1:0] wbits,
  input  logic [NUM_CH-1:0] expire,
  output logic [NUM_CH-1:0] raw,
  output logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] masked,
  output logic              irq
);
  logic [NUM_CH-1:0] raw_d, mask_d, clr_bits;

  assign clr_bits = wr_clr ? wbits : '0;

  always_comb begin
    raw_d  = (raw & ~clr_bits) | expire;
    mask_d = wr_mask ? wbits : mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw  <= raw_d;
      mask <= mask_d;
    end
  end

  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/qtick_timer.sv
module qtick_timer
  import qtick_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [NUM_CH-1:0]            expire_vec, raw_vec, mask_vec, mskd_vec;
  logic [NUM_CH-1:0][REG_W-1:0] ch_count, ch_load, ch_bgnd, ch_ctrl, ch_cnt;

  logic sel_mask, sel_clr;
  assign sel_mask = (bus_addr == ADDR_W'(OFS_MASK));
  assign sel_clr  = (bus_addr == ADDR_W'(OFS_CLR));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int unsigned BASE = CH_BASE + CH_STRIDE * i;
    logic wr_load, wr_ctrl, wr_bgnd;
    assign wr_load = bus_we && (bus_addr == ADDR_W'(BASE + CH_LOAD));
    assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(BASE + CH_CTRL));
    assign wr_bgnd = bus_we && (bus_addr == ADDR_W'(BASE + CH_BGND));

    qtick_channel #(.CW(REG_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .wr_load  (wr_load),
      .wr_ctrl  (wr_ctrl),
      .wr_bgnd  (wr_bgnd),
      .wdata    (bus_wdata),
      .count_rd (ch_count[i]),
      .load_rd  (ch_load[i]),
      .bgnd_rd  (ch_bgnd[i]),
      .ctrl_rd  (ch_ctrl[i]),
      .cnt_raw  (ch_cnt[i]),
      .expire   (expire_vec[i])
    );
  end

  qtick_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mask (bus_we && sel_mask),
    .wr_clr  (bus_we && sel_clr),
    .wbits   (bus_wdata[NUM_CH-1:0]),
    .expire  (expire_vec),
    .raw     (raw_vec),
    .mask    (mask_vec),
    .masked  (mskd_vec),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_MASK)) bus_rdata = REG_W'(mask_vec);
    if (bus_addr == ADDR_W'(OFS_RAW))  bus_rdata = REG_W'(raw_vec);
    if (bus_addr == ADDR_W'(OFS_MSKD)) bus_rdata = REG_W'(mskd_vec);
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + CH_LOAD))  bus_rdata = ch_load[i];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + CH_COUNT)) bus_rdata = ch_count[i];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + CH_CTRL))  bus_rdata = ch_ctrl[i];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + CH_BGND))  bus_rdata = ch_bgnd[i];
    end
  end
endmodule

// File: rtl/qtick_timer_chk.sv
module qtick_timer_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned REG_W  = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_we,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [REG_W-1:0]             bus_wdata,
  input logic [REG_W-1:0]             bus_rdata,
  input logic                         irq,
  input logic [NUM_CH-1:0]            expire_vec,
  input logic [NUM_CH-1:0]            raw_vec,
  input logic [NUM_CH-1:0][REG_W-1:0] ch_cnt
);
  // R11: masked-status read and irq pin agree
  assert_irq_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h08)) |-> ((bus_rdata != '0) == irq));

  // R9: every expiry lands in raw status
  assert_expiry_sets_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_vec != '0) |=> ((raw_vec & $past(expire_vec)) == $past(expire_vec)));

  // R10: raw bits fall only after a clear write
  assert_raw_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == ADDR_W'('h0C)) |=> ((raw_vec & $past(raw_vec)) == $past(raw_vec)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ld
    // R3: start-value write lands in the count
    assert_load_sets_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'('h10 + 'h10 * i)) |=> (ch_cnt[i] == $past(bus_wdata)));
  end
endmodule

bind qtick_timer qtick_timer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .expire_vec (expire_vec),
  .raw_vec    (raw_vec),
  .ch_cnt     (ch_cnt)
);

// File: tb/qtick_timer_tb.sv
module qtick_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qtick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference state, derived from the requirement list
  logic [31:0] m_cnt [4];
  logic [31:0] m_bg  [4];
  logic [31:0] m_ld  [4];
  logic [7:0]  m_ctl [4];
  logic [7:0]  m_pre [4];
  logic [3:0]  m_mask, m_raw;

  function automatic logic [31:0] m_eff(input int i);
    return m_ctl[i][1] ? m_cnt[i] : {16'h0, m_cnt[i][15:0]};
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h00) return {28'h0, m_mask};
    if (a == 8'h04) return {28'h0, m_raw};
    if (a == 8'h08) return {28'h0, m_raw & m_mask};
    for (int i = 0; i < 4; i++) begin
      if (a == 8'(16 + 16*i))  return m_ld[i];
      if (a == 8'(20 + 16*i))  return m_eff(i);
      if (a == 8'(24 + 16*i))  return {24'h0, m_ctl[i]};
      if (a == 8'(28 + 16*i))  return m_bg[i];
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h00 || a == 8'h08) return "R11";
    if (a == 8'h04) return "R9";
    if (a < 8'h10)  return "R10";
    case (a[3:2])
      2'd0: return "R2";
      2'd1: return "R5";
      2'd2: return "R12";
      default: return "R7";
    endcase
  endfunction

  task automatic model_step(input logic [7:0] a, input logic w, input logic [31:0] d, input logic t);
    logic [3:0] ex;
    ex = '0;
    for (int i = 0; i < 4; i++) begin
      logic wl, wc, wb, run, step, fire;
      logic [7:0] pm;
      logic [31:0] e;
      wl = w && a == 8'(16 + 16*i);
      wc = w && a == 8'(24 + 16*i);
      wb = w && a == 8'(28 + 16*i);
      run = t && m_ctl[i][7];
      pm = (m_ctl[i][3:2] == 2'b00) ? 8'h00 : (m_ctl[i][3:2] == 2'b01) ? 8'h0F : 8'hFF;
      step = run && ((m_pre[i] & pm) == pm);
      fire = step && !wl;
      e = m_eff(i);
      if (wl) m_pre[i] = 8'h0;
      else if (run) m_pre[i] = m_pre[i] + 8'h1;
      if (wl) begin
        m_cnt[i] = d; m_bg[i] = d; m_ld[i] = d;
      end else if (fire) begin
        if (e == 0) begin
          ex[i] = 1'b1;
          if (m_ctl[i][0])      m_cnt[i] = 32'h0;
          else if (m_ctl[i][6]) m_cnt[i] = m_bg[i];
          else                  m_cnt[i] = m_ctl[i][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        end else m_cnt[i] = e - 1;
      end
      if (wb) m_bg[i] = d;
      if (wc) m_ctl[i] = d[7:0] & 8'hCF;
      else if (ex[i] && m_ctl[i][0]) m_ctl[i][7] = 1'b0;
    end
    m_raw = (m_raw & ~((w && a == 8'h0C) ? d[3:0] : 4'h0)) | ex;
    if (w && a == 8'h00) m_mask = d[3:0];
  endtask

  task automatic cycle(input logic [7:0] a, input logic w, input logic [31:0] d, input logic t);
    @(negedge clk);
    bus_addr = a; bus_we = w; bus_wdata = d; tick_en = t;
    @(posedge clk);
    model_step(a, w, d, t);
    #1;
    bus_we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cycle(8'h04, 1'b0, 32'h0, 1'b1);
  endtask

  task automatic chk_val(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; #1;
    n_vec++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    n_vec++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  task automatic chk_model(input logic [7:0] a);
    chk_val(a, m_read(a), tag_of(a));
    chk_irq(|(m_raw & m_mask), "R11");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) begin
      m_cnt[i] = 0; m_bg[i] = 0; m_ld[i] = 0; m_ctl[i] = 0; m_pre[i] = 0;
    end
    m_mask = 0; m_raw = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 'h50; a += 4) chk_val(8'(a), 32'h0, "R1");
    chk_irq(1'b0, "R1");

    // R2 / R3: start value fans out to count and background
    cycle(8'h20, 1, 32'h1234, 0);
    chk_val(8'h20, 32'h1234, "R2");
    chk_val(8'h24, 32'h1234, "R3");
    chk_val(8'h2C, 32'h1234, "R3");

    // R12: unused control bits and count-register writes
    cycle(8'h38, 1, 32'hFFFF_FF30, 0);
    chk_val(8'h38, 32'h0, "R12");
    cycle(8'h34, 1, 32'h5, 0);
    chk_val(8'h34, 32'h0, "R12");

    // R4: divide by 16
    cycle(8'h10, 1, 32'h5, 0);
    cycle(8'h18, 1, 32'h86, 0);
    ticks(15);
    chk_val(8'h14, 32'h5, "R4");
    ticks(1);
    chk_val(8'h14, 32'h4, "R4");

    // R6 / R9: 16-bit free-running wrap
    cycle(8'h40, 1, 32'h1, 0);
    cycle(8'h48, 1, 32'h80, 0);
    ticks(1);
    chk_val(8'h44, 32'h0, "R5");
    ticks(1);
    chk_val(8'h44, 32'h0000_FFFF, "R6");
    chk_val(8'h04, 32'h8, "R9");

    // R10: clear, then clear colliding with expiry
    cycle(8'h0C, 1, 32'h8, 0);
    chk_val(8'h04, 32'h0, "R10");
    cycle(8'h40, 1, 32'h0, 0);
    cycle(8'h0C, 1, 32'h8, 1);
    chk_val(8'h04, 32'h8, "R10");
    chk_val(8'h0C, 32'h0, "R10");

    // R11: mask gating
    cycle(8'h00, 1, 32'h8, 0);
    chk_val(8'h08, 32'h8, "R11");
    chk_irq(1'b1, "R11");
    cycle(8'h0C, 1, 32'h8, 0);
    chk_irq(1'b0, "R11");

    // R7: periodic reload from background
    cycle(8'h30, 1, 32'h2, 0);
    cycle(8'h38, 1, 32'hC2, 0);
    cycle(8'h3C, 1, 32'd10, 0);
    chk_val(8'h34, 32'h2, "R7");
    chk_val(8'h30, 32'h2, "R2");
    ticks(2);
    chk_val(8'h34, 32'h0, "R7");
    ticks(1);
    chk_val(8'h34, 32'd10, "R7");
    chk_val(8'h04, 32'h4, "R9");
    chk_irq(1'b0, "R11");
    cycle(8'h38, 1, 32'h0, 0);
    cycle(8'h0C, 1, 32'h4, 0);

    // R8: one-shot stop, priority over periodic bit
    cycle(8'h20, 1, 32'h1, 0);
    cycle(8'h28, 1, 32'hC3, 0);
    ticks(2);
    chk_val(8'h24, 32'h0, "R8");
    chk_val(8'h28, 32'h43, "R8");
    chk_val(8'h04, 32'h2, "R8");
    cycle(8'h0C, 1, 32'h2, 0);
    ticks(2);
    chk_val(8'h24, 32'h0, "R8");
    chk_val(8'h04, 32'h0, "R8");

    // R6: 32-bit wrap
    cycle(8'h10, 1, 32'h0, 0);
    cycle(8'h18, 1, 32'h82, 0);
    ticks(1);
    chk_val(8'h14, 32'hFFFF_FFFF, "R6");
    chk_val(8'h04, 32'h1, "R9");

    // R4: code 11 divides by 256
    cycle(8'h30, 1, 32'h3, 0);
    cycle(8'h38, 1, 32'h8E, 0);
    ticks(255);
    chk_val(8'h34, 32'h3, "R4");
    ticks(1);
    chk_val(8'h34, 32'h2, "R4");

    // random phase against the reference state
    cycle(8'h0C, 1, 32'hF, 0);
    cycle(8'h00, 1, 32'hF, 0);
    for (int n = 0; n < 4000; n++) begin
      int idx;
      logic [7:0] a;
      logic [31:0] d;
      logic w;
      idx = int'($urandom % 20);
      a = (idx < 4) ? 8'(idx * 4) : 8'(16 + (idx - 4) * 4);
      w = ($urandom % 4) == 0;
      d = $urandom % 6;
      if (a >= 8'h10 && a[3:2] == 2'd2) begin
        d = $urandom & 32'hFF;
        if ($urandom % 4 != 0) d[3:2] = 2'b00;
      end else if ($urandom % 8 == 0) d = $urandom;
      cycle(a, w, d, ($urandom % 4) != 0);
      chk_model(8'(($urandom % 20) < 4 ? ($urandom % 4) * 4 : 16 + ($urandom % 16) * 4));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule